// File: doc/BRIEF.md
# Left-Justified Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, serial data) driven by an external master. It recovers the left and right samples in left-justified framing. The word clock is high for the left channel and low for the right. Each channel's most significant bit arrives on the first active bit-clock edge after a word-clock transition, unless a programmable bit offset pushes it later. The active edge is the rising edge by default, or the falling edge when the inversion control is set. A two-bit word-length code selects 16, 20, 24 or 32 bits. Each sample is presented MSB-aligned in a 32-bit word.

The serial pins are oversampled by a fast system clock after a short synchronizer. Bit-clock edges are found by comparing successive samples, so everything runs in one clock domain. Once the right channel's last bit has been taken, both samples appear together with a one-cycle valid strobe.

The block also counts bit clocks per frame, from one rising word-clock edge to the next. It raises a configuration-error flag when the measured geometry cannot hold the programmed word length and offset.

Top module: `lj_audio_rx`

## Requirements
- R1: Only mode code 2'b11 enables reception. Any other code holds the block idle: no valid strobe, both sample outputs read zero, the error flag reads zero, and framing is re-acquired after a return to 2'b11.
- R2: With offset 0, the left sample's MSB is the data bit taken on the first active bit-clock edge that sees the word clock high after it was low. The following bits follow MSB first.
- R3: With offset 0, the right sample's MSB is the data bit taken on the first active edge that sees the word clock low after it was high. The following bits follow MSB first.
- R4: An offset of k makes each channel's MSB the bit on the (k+1)-th active edge of its half-frame, so the first k bits are skipped.
- R5: With the inversion control at 1, falling bit-clock edges are the active edges. Framing is otherwise unchanged.
- R6: Word-length code 0 selects 16 bits, 1 selects 20, 2 selects 24 and 3 selects 32. The sample occupies the upper bits of the 32-bit output, and the bits below it read zero.
- R7: Bits of a half-frame before the offset or after the last bit of the word length do not change the received sample.
- R8: When the right sample's last bit is taken, the left and right samples of that frame appear together with a valid strobe that is high for exactly one clock cycle. Exactly one strobe is raised per frame.
- R9: The error flag is set when N, the bit clocks per frame counted between successive rising word-clock edges, is at most twice the word length.
- R10: The error flag is set when the offset exceeds N minus the word length.
- R11: After reset, the valid strobe, the error flag and both samples read zero.
- R12: The error flag is re-evaluated only at the start of each left half-frame, from the count of the frame just ended. The first left half-frame after the block is enabled leaves the flag at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Framing mode; 2'b11 enables reception |
| cfg_wlen | input | 2 | Word-length code (16/20/24/32 bits) |
| cfg_offset | input | OFF_W | Bit clocks skipped before each MSB |
| cfg_bclk_inv | input | 1 | 1 makes the falling bit-clock edge active |
| bclk_in | input | 1 | Serial bit clock from the master |
| wclk_in | input | 1 | Word clock; high for left, low for right |
| sdata_in | input | 1 | Serial audio data |
| left_sample | output | 32 | Received left sample, MSB-aligned |
| right_sample | output | 32 | Received right sample, MSB-aligned |
| sample_valid | output | 1 | One-cycle strobe when a stereo pair is ready |
| cfg_error | output | 1 | Frame geometry violates the configuration rules |

## Verification
The embedded properties check, on every cycle, the rules that do not depend on the serial content. The strobe lasts a single cycle and is silent while the block is idle. The error flag is zero when idle and moves only at a left half-frame start. The bits below the word length are zero whenever a pair is presented. Whether the right bits land in the right positions can only be shown by the bench's scenarios: MSB placement after each word-clock edge, offset skipping, edge inversion, and the ignoring of surplus bits. The bench sweeps every word length, several offsets and both polarities, and compares against samples it builds arithmetically. The geometry scenarios do the same for the error flag, both exactly at and one bit past each limit, and for the one-frame delay before the flag can first rise.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;

  localparam int SAMPLE_W = 32;
  localparam logic [1:0] MODE_LEFT_JUST = 2'b11;

  typedef enum logic [1:0] {
    WLEN_16 = 2'd0,
    WLEN_20 = 2'd1,
    WLEN_24 = 2'd2,
    WLEN_32 = 2'd3
  } wlen_code_e;

  // Number of data bits carried by each word-length code.
  function automatic logic [6:0] wlen_bits(input wlen_code_e code);
    case (code)
      WLEN_16: wlen_bits = 7'd16;
      WLEN_20: wlen_bits = 7'd20;
      WLEN_24: wlen_bits = 7'd24;
      default: wlen_bits = 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lj_rx_tracker.sv
// Finds active bit-clock edges, detects word-clock transitions at bit
// resolution and counts the position within the current half-frame.
module lj_rx_tracker #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             inv,
  input  logic             bclk,
  input  logic             wclk,
  output logic             tick,
  output logic             half_start,
  output logic             in_frame_now,
  output logic [CNT_W-1:0] pos_now
);

  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic             bclk_q;
  logic             ws_prev;
  logic             armed;
  logic             in_frame;
  logic [CNT_W-1:0] pos_reg;

  always_comb begin
    tick         = enable && (inv ? (bclk_q && !bclk) : (!bclk_q && bclk));
    half_start   = tick && armed && (wclk != ws_prev);
    in_frame_now = in_frame || half_start;
    if (half_start)            pos_now = '0;
    else if (pos_reg == POS_MAX) pos_now = POS_MAX;
    else                       pos_now = pos_reg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q   <= 1'b0;
      ws_prev  <= 1'b0;
      armed    <= 1'b0;
      in_frame <= 1'b0;
      pos_reg  <= '0;
    end else if (!enable) begin
      bclk_q   <= bclk;
      armed    <= 1'b0;
      in_frame <= 1'b0;
      pos_reg  <= '0;
    end else begin
      bclk_q <= bclk;
      if (tick) begin
        ws_prev <= wclk;
        armed   <= 1'b1;
        if (half_start)   in_frame <= 1'b1;
        if (in_frame_now) pos_reg  <= pos_now;
      end
    end
  end

endmodule

// File: rtl/lj_rx_capture.sv
// Places bits of the capture window into an MSB-aligned word and
// presents the stereo pair once the right channel is complete.
module lj_rx_capture
  import lj_rx_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int OFF_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                tick,
  input  logic                ws,
  input  logic                sd,
  input  logic                half_start,
  input  logic                in_frame_now,
  input  logic [CNT_W-1:0]    pos_now,
  input  logic [OFF_W-1:0]    offset,
  input  logic [6:0]          wl_bits,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid
);

  logic [SAMPLE_W-1:0] acc;
  logic [SAMPLE_W-1:0] acc_next;
  logic [SAMPLE_W-1:0] left_hold;
  logic [CNT_W-1:0]    off_ext;
  logic [CNT_W-1:0]    wl_ext;
  logic [CNT_W-1:0]    idx;
  logic [CNT_W-1:0]    tgt;
  logic                in_win;
  logic                capture;
  logic                last_bit;

  always_comb begin
    off_ext  = CNT_W'(offset);
    wl_ext   = CNT_W'(wl_bits);
    idx      = pos_now - off_ext;
    in_win   = (pos_now >= off_ext) && (idx < wl_ext);
    capture  = tick && in_frame_now && in_win;
    last_bit = capture && (idx == wl_ext - 1'b1);
    tgt      = CNT_W'(SAMPLE_W - 1) - idx;
    acc_next = half_start ? '0 : acc;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (capture && (tgt == CNT_W'(i))) acc_next[i] = sd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      acc          <= '0;
      left_hold    <= '0;
      left_sample  <= '0;
      right_sample <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (tick) acc <= acc_next;
      if (last_bit && ws) left_hold <= acc_next;
      if (last_bit && !ws) begin
        left_sample  <= left_hold;
        right_sample <= acc_next;
        sample_valid <= 1'b1;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sample_valid);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_tail_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && $stable(wl_bits)) |->
      (((right_sample << wl_bits) == '0) && ((left_sample << wl_bits) == '0)));

endmodule

// File: rtl/lj_rx_geom.sv
// Measures bit clocks per frame and checks them against word length
// and offset at every left half-frame start.
module lj_rx_geom #(
  parameter int CNT_W = 10,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick,
  input  logic             left_start,
  input  logic [OFF_W-1:0] offset,
  input  logic [6:0]       wl_bits,
  output logic             cfg_error
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] fcnt;
  logic             meas_ok;
  logic [CNT_W:0]   n_ext;
  logic [CNT_W:0]   two_wl;
  logic [CNT_W:0]   need;
  logic             geom_bad;

  always_comb begin
    n_ext    = {1'b0, fcnt};
    two_wl   = (CNT_W+1)'(wl_bits) << 1;
    need     = (CNT_W+1)'(offset) + (CNT_W+1)'(wl_bits);
    geom_bad = (n_ext <= two_wl) || (need > n_ext);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fcnt      <= '0;
      meas_ok   <= 1'b0;
      cfg_error <= 1'b0;
    end else if (tick) begin
      if (left_start) begin
        if (meas_ok) cfg_error <= geom_bad;
        fcnt    <= CNT_W'(1);
        meas_ok <= 1'b1;
      end else if (meas_ok && fcnt != CNT_MAX) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assert_err_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !cfg_error);

  assert_err_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (enable && !(tick && left_start)) |=> $stable(cfg_error));

endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx
  import lj_rx_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int OFF_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_wlen,
  input  logic [OFF_W-1:0]    cfg_offset,
  input  logic                cfg_bclk_inv,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                cfg_error
);

  logic [2:0]       pins_s;
  logic             bclk_s;
  logic             wclk_s;
  logic             sd_s;
  logic             enable;
  logic [6:0]       wl_bits;
  logic             tick;
  logic             half_start;
  logic             in_frame_now;
  logic [CNT_W-1:0] pos_now;
  logic             left_start;

  lj_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({bclk_in, wclk_in, sdata_in}),
    .dout (pins_s)
  );

  assign bclk_s     = pins_s[2];
  assign wclk_s     = pins_s[1];
  assign sd_s       = pins_s[0];
  assign enable     = (cfg_mode == MODE_LEFT_JUST);
  assign wl_bits    = wlen_bits(wlen_code_e'(cfg_wlen));
  assign left_start = half_start && wclk_s;

  lj_rx_tracker #(.CNT_W(CNT_W)) trk_i (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .inv          (cfg_bclk_inv),
    .bclk         (bclk_s),
    .wclk         (wclk_s),
    .tick         (tick),
    .half_start   (half_start),
    .in_frame_now (in_frame_now),
    .pos_now      (pos_now)
  );

  lj_rx_capture #(.CNT_W(CNT_W), .OFF_W(OFF_W)) cap_i (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .tick         (tick),
    .ws           (wclk_s),
    .sd           (sd_s),
    .half_start   (half_start),
    .in_frame_now (in_frame_now),
    .pos_now      (pos_now),
    .offset       (cfg_offset),
    .wl_bits      (wl_bits),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid)
  );

  lj_rx_geom #(.CNT_W(CNT_W), .OFF_W(OFF_W)) geo_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .left_start (left_start),
    .offset     (cfg_offset),
    .wl_bits    (wl_bits),
    .cfg_error  (cfg_error)
  );

endmodule

// File: tb/lj_audio_rx_tb_top.sv
`timescale 1ns/1ps
module lj_audio_rx_tb_top;

  localparam int OFF_W = 6;
  localparam int HALF  = 3;
  localparam int NFR   = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_mode = 2'b00;
  logic [1:0]       cfg_wlen = 2'b00;
  logic [OFF_W-1:0] cfg_offset = '0;
  logic             cfg_bclk_inv = 1'b0;
  logic             bclk_in = 1'b0;
  logic             wclk_in = 1'b0;
  logic             sdata_in = 1'b0;
  logic [31:0]      left_sample;
  logic [31:0]      right_sample;
  logic             sample_valid;
  logic             cfg_error;

  int vecs  = 0;
  int fails = 0;
  int ngot  = 0;
  logic [31:0] got_l [512];
  logic [31:0] got_r [512];
  logic prev_v = 1'b0;

  always #2 clk = ~clk;

  lj_audio_rx dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_wlen     (cfg_wlen),
    .cfg_offset   (cfg_offset),
    .cfg_bclk_inv (cfg_bclk_inv),
    .bclk_in      (bclk_in),
    .wclk_in      (wclk_in),
    .sdata_in     (sdata_in),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid),
    .cfg_error    (cfg_error)
  );

  // Collect presented pairs; the strobe must last one cycle (R8).
  always @(negedge clk) begin
    if (sample_valid) begin
      if (prev_v) begin
        vecs++; fails++;
        $display("FAIL R8 strobe width: actual 2+ cycles expected 1");
      end
      if (ngot < 512) begin
        got_l[ngot] = left_sample;
        got_r[ngot] = right_sample;
      end
      ngot++;
    end
    prev_v = sample_valid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wl_of(input int code);
    case (code)
      0: return 16;
      1: return 20;
      2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int wl);
    return 32'hFFFF_FFFF << (32 - wl);
  endfunction

  function automatic logic [31:0] lval_of(input int c, input int f);
    return (32'h9E37_79B9 * (f + 1)) ^ (c << 8) ^ 32'h0F1E_2D3C;
  endfunction

  function automatic logic [31:0] rval_of(input int c, input int f);
    logic [31:0] l;
    l = lval_of(c, f);
    return {l[15:0], l[31:16]} ^ 32'h5A5A_0FF0;
  endfunction

  // One bit period: inactive edge with new data, then the active edge.
  task automatic send_bit(input logic ws, input logic sd);
    bclk_in  = cfg_bclk_inv;
    wclk_in  = ws;
    sdata_in = sd;
    repeat (HALF) @(negedge clk);
    bclk_in = ~cfg_bclk_inv;
    repeat (HALF) @(negedge clk);
  endtask

  // Half-frame: junk outside the window [off, off+wl), sample bits inside (R7).
  task automatic send_half(input logic ws, input int nb, input logic [31:0] val,
                           input int wl, input int off);
    for (int p = 0; p < nb; p++) begin
      if (p >= off && (p - off) < wl) send_bit(ws, val[31 - (p - off)]);
      else                            send_bit(ws, ~val[p % 32]);
    end
  endtask

  task automatic go_idle();
    cfg_mode = 2'b00;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_cfg(input int c, input int wcode, input int off, input logic inv);
    int wl, hb, start_n;
    string tag;
    wl = wl_of(wcode);
    hb = wl + 4;
    go_idle();
    cfg_wlen = wcode[1:0];
    cfg_offset = off[OFF_W-1:0];
    cfg_bclk_inv = inv;
    bclk_in = inv;
    repeat (4) @(negedge clk);
    cfg_mode = 2'b11;
    start_n = ngot;
    send_half(1'b0, hb, 32'h0, 0, 0);
    for (int f = 0; f < NFR; f++) begin
      send_half(1'b1, hb, lval_of(c, f), wl, off);
      send_half(1'b0, hb, rval_of(c, f), wl, off);
    end
    repeat (12) @(negedge clk);
    check("R8 pair count", 32'(ngot - start_n), 32'(NFR));
    tag = inv ? "R5" : (off != 0 ? "R4" : "R2/R3");
    for (int f = 0; f < NFR; f++) begin
      check({tag, " left R6/R7"},  got_l[start_n + f], lval_of(c, f) & mask_of(wl));
      check({tag, " right R6/R7"}, got_r[start_n + f], rval_of(c, f) & mask_of(wl));
    end
    check("R9 legal geometry no error", 32'(cfg_error), 32'd0);
  endtask

  // Geometry scenario with unequal halves; error read after nfr frames.
  task automatic run_geom(input int lb, input int rb, input int off, input int nfr,
                          input logic exp_err, input string req);
    go_idle();
    cfg_wlen = 2'd0;
    cfg_offset = off[OFF_W-1:0];
    cfg_bclk_inv = 1'b0;
    bclk_in = 1'b0;
    cfg_mode = 2'b11;
    send_half(1'b0, rb, 32'h0, 0, 0);
    for (int f = 0; f < nfr; f++) begin
      send_half(1'b1, lb, lval_of(99, f), 16, off);
      send_half(1'b0, rb, rval_of(99, f), 16, off);
    end
    repeat (8) @(negedge clk);
    check(req, 32'(cfg_error), 32'(exp_err));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    vecs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin : main
    int c;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset valid", 32'(sample_valid), 32'd0);
    check("R11 reset error", 32'(cfg_error), 32'd0);
    check("R11 reset left", left_sample, 32'd0);
    check("R11 reset right", right_sample, 32'd0);

    c = 0;
    for (int w = 0; w < 4; w++) begin
      for (int oi = 0; oi < 3; oi++) begin
        for (int iv = 0; iv < 2; iv++) begin
          run_cfg(c, w, (oi == 2) ? 3 : oi, iv[0]);
          c++;
        end
      end
    end

    // R12: first frame leaves the flag low even with illegal geometry (N = 2*wl).
    run_geom(16, 16, 0, 1, 1'b0, "R12 first frame unchecked");
    // Second left start measures N = 32 = 2*wl: error (R9).
    send_half(1'b1, 16, 32'h0, 16, 0);
    repeat (8) @(negedge clk);
    check("R9 N equal 2*wl", 32'(cfg_error), 32'd1);
    // R1: idle clears the flag and outputs.
    cfg_mode = 2'b10;
    repeat (8) @(negedge clk);
    check("R1 idle clears error", 32'(cfg_error), 32'd0);
    check("R1 idle clears left", left_sample, 32'd0);

    run_geom(17, 16, 0, 3, 1'b0, "R9 N = 2*wl+1 legal");
    run_geom(18, 18, 20, 3, 1'b0, "R10 offset = N-wl legal");
    run_geom(18, 18, 21, 3, 1'b1, "R10 offset > N-wl");

    // R1: non-left-justified mode ignores a well-formed stream.
    go_idle();
    cfg_mode = 2'b01;
    cfg_offset = '0;
    n0 = ngot;
    send_half(1'b0, 20, 32'h0, 0, 0);
    for (int f = 0; f < 2; f++) begin
      send_half(1'b1, 20, lval_of(7, f), 16, 0);
      send_half(1'b0, 20, rval_of(7, f), 16, 0);
    end
    repeat (8) @(negedge clk);
    check("R1 idle no strobe", 32'(ngot - n0), 32'd0);
    check("R1 idle right zero", right_sample, 32'd0);
    check("R1 idle error zero", 32'(cfg_error), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule